// File: doc/BRIEF.md
# Search-Mode Envelope Monitor

This block watches a single sliced envelope bit taken from the auxiliary track of a tape while the transport fast-winds in search mode. A slow tick marks each auxiliary block period. When the envelope stays at one level for a fixed number of block ticks, the block declares either a label region (envelope high) or blank, unrecorded tape (envelope low).

At the same time it times every high burst of the envelope in prescaled clock periods. The result is a speed word with three fields: a 5-bit count, a 2-bit range and an invalid flag. Relative tape speed is 51.2 × 2^range / count, and a count of zero means the speed is above what the current range can show. The prescaler divisor halves with each range step. The range moves by itself toward the band where counts are useful.

Outside search mode every output is forced low and all internal state is cleared.

Top module: `aux_env_monitor`

## Requirements
- R1: In search mode, `label` rises once the envelope has stayed high for HOLD_BLOCKS consecutive block ticks counted after its last change, and `virgin` is low at that point.
- R2: `label` falls once the envelope has stayed low for HOLD_BLOCKS consecutive block ticks.
- R3: `virgin` rises after HOLD_BLOCKS ticks of steady low envelope and clears after HOLD_BLOCKS ticks of steady high envelope.
- R4: An envelope run shorter than HOLD_BLOCKS ticks leaves both flags unchanged, and any envelope change restarts the tick count.
- R5: While `search_en` is low, every output reads zero from the next clock on, and all state is cleared.
- R6: In search mode `env_out` equals `env_in` delayed by one clock.
- R7: When a burst ends, `spd_count` becomes min(31, floor((H-1)/(BASE_DIV >> r))). H is the number of clocks `env_out` was high and r is the range in use. `spd_range` reports r.
- R8: A finished burst with a count below LOW_LIM while r < 3 raises the range by one and sets `spd_invalid`.
- R9: A finished burst with a count above HIGH_LIM while r > 0 lowers the range by one and sets `spd_invalid`.
- R10: Any other finished burst clears `spd_invalid`. This includes a count below LOW_LIM at range 3 and a count above HIGH_LIM at range 0.
- R11: On entry to search mode, `spd_invalid` reads 1 and the range restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| search_en | input | 1 | High while the transport is in search mode |
| env_in | input | 1 | Sliced envelope bit of the auxiliary track |
| blk_tick | input | 1 | One-clock pulse per auxiliary block period |
| env_out | output | 1 | Registered envelope, gated by search mode |
| label | output | 1 | Label region detected |
| virgin | output | 1 | Unrecorded tape detected |
| spd_invalid | output | 1 | Speed count and range not yet valid |
| spd_count | output | 5 | Burst length in prescaled periods |
| spd_range | output | 2 | Prescaler range used for `spd_count` |

## Verification
The bench builds the block with HOLD_BLOCKS = 4 and BASE_DIV = 32. With these values a persistence decision needs only a dozen clocks of ticks, and the prescaler divisor runs from 32 down to 4. Burst lengths that rise and then fall in steps of 11 clocks, up to about 1100, then walk the range up through all four steps and back down. The same sweep reaches count saturation at range 0 and small, still-valid counts at range 3. A software model of the range controller predicts every count, range and invalid flag.

// File: rtl/aux_env_pkg.sv
package aux_env_pkg;
  localparam int SPD_CNT_W = 5;
  localparam int SPD_RNG_W = 2;

  typedef struct packed {
    logic                 invalid;
    logic [SPD_CNT_W-1:0] count;
    logic [SPD_RNG_W-1:0] range;
  } spd_word_t;
endpackage

// File: rtl/env_persist.sv
// Level-persistence timer: declares label / blank tape after a steady run.
module env_persist #(
  parameter int HOLD_BLOCKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic search_en,
  input  logic env_now,
  input  logic env_held,
  input  logic blk_tick,
  output logic label_o,
  output logic virgin_o
);
  localparam int RUN_W = $clog2(HOLD_BLOCKS + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(HOLD_BLOCKS);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !search_en) begin
      run_q    <= '0;
      label_o  <= 1'b0;
      virgin_o <= 1'b0;
    end else begin
      if (env_now != env_held)
        run_q <= '0;
      else if (blk_tick && run_q != RUN_FULL)
        run_q <= run_q + 1'b1;
      if (run_q == RUN_FULL) begin
        label_o  <= env_held;
        virgin_o <= ~env_held;
      end
    end
  end
endmodule

// File: rtl/burst_timer.sv
// Measures envelope-high bursts in prescaled clock periods.
module burst_timer #(
  parameter int BASE_DIV = 64,
  parameter int CNT_W    = 5,
  parameter int RNG_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             search_en,
  input  logic             burst_start,
  input  logic             burst_live,
  input  logic [RNG_W-1:0] range_i,
  output logic [CNT_W-1:0] len_o
);
  localparam int PRE_W = $clog2(BASE_DIV);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] div_m1;

  assign div_m1 = PRE_W'((BASE_DIV >> range_i) - 1);

  always_ff @(posedge clk) begin
    if (rst || !search_en) begin
      pre_q <= '0;
      len_o <= '0;
    end else if (burst_start) begin
      pre_q <= '0;
      len_o <= '0;
    end else if (burst_live) begin
      if (pre_q == div_m1) begin
        pre_q <= '0;
        if (len_o != CNT_TOP)
          len_o <= len_o + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/range_ctrl.sv
// Auto-ranging controller and speed word register.
module range_ctrl
  import aux_env_pkg::*;
#(
  parameter int LOW_LIM  = 4,
  parameter int HIGH_LIM = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 search_en,
  input  logic                 burst_end,
  input  logic [SPD_CNT_W-1:0] len_i,
  output logic [SPD_RNG_W-1:0] range_o,
  output spd_word_t            spd_o
);
  localparam logic [SPD_RNG_W-1:0] RNG_TOP = {SPD_RNG_W{1'b1}};

  logic seen_q;
  logic step_up;
  logic step_dn;

  assign step_up = (len_i < SPD_CNT_W'(LOW_LIM)) && (range_o != RNG_TOP);
  assign step_dn = (len_i > SPD_CNT_W'(HIGH_LIM)) && (range_o != '0);

  always_ff @(posedge clk) begin
    if (rst || !search_en) begin
      range_o <= '0;
      spd_o   <= '0;
      seen_q  <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (!seen_q)
        spd_o.invalid <= 1'b1;
      if (burst_end) begin
        spd_o.count   <= len_i;
        spd_o.range   <= range_o;
        spd_o.invalid <= step_up | step_dn;
        if (step_up)
          range_o <= range_o + 1'b1;
        else if (step_dn)
          range_o <= range_o - 1'b1;
      end
    end
  end
endmodule

// File: rtl/aux_env_monitor.sv
module aux_env_monitor
  import aux_env_pkg::*;
#(
  parameter int HOLD_BLOCKS = 8,
  parameter int BASE_DIV    = 64,
  parameter int LOW_LIM     = 4,
  parameter int HIGH_LIM    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 search_en,
  input  logic                 env_in,
  input  logic                 blk_tick,
  output logic                 env_out,
  output logic                 label,
  output logic                 virgin,
  output logic                 spd_invalid,
  output logic [SPD_CNT_W-1:0] spd_count,
  output logic [SPD_RNG_W-1:0] spd_range
);
  logic                 env_q;
  logic                 burst_start;
  logic                 burst_live;
  logic                 burst_end;
  logic [SPD_CNT_W-1:0] len_w;
  logic [SPD_RNG_W-1:0] cur_range;
  spd_word_t            spd_w;

  always_ff @(posedge clk) begin
    if (rst || !search_en)
      env_q <= 1'b0;
    else
      env_q <= env_in;
  end

  assign burst_start = env_in & ~env_q;
  assign burst_live  = env_in & env_q;
  assign burst_end   = env_q & ~env_in;

  env_persist #(.HOLD_BLOCKS(HOLD_BLOCKS)) u_persist (
    .clk      (clk),
    .rst      (rst),
    .search_en(search_en),
    .env_now  (env_in),
    .env_held (env_q),
    .blk_tick (blk_tick),
    .label_o  (label),
    .virgin_o (virgin)
  );

  burst_timer #(
    .BASE_DIV(BASE_DIV),
    .CNT_W   (SPD_CNT_W),
    .RNG_W   (SPD_RNG_W)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .search_en  (search_en),
    .burst_start(burst_start),
    .burst_live (burst_live),
    .range_i    (cur_range),
    .len_o      (len_w)
  );

  range_ctrl #(
    .LOW_LIM (LOW_LIM),
    .HIGH_LIM(HIGH_LIM)
  ) u_range (
    .clk      (clk),
    .rst      (rst),
    .search_en(search_en),
    .burst_end(burst_end),
    .len_i    (len_w),
    .range_o  (cur_range),
    .spd_o    (spd_w)
  );

  assign env_out     = env_q;
  assign spd_invalid = spd_w.invalid;
  assign spd_count   = spd_w.count;
  assign spd_range   = spd_w.range;
endmodule

// File: rtl/aux_env_monitor_chk.sv
module aux_env_monitor_chk
  import aux_env_pkg::*;
#(
  parameter int LOW_LIM  = 4,
  parameter int HIGH_LIM = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 search_en,
  input logic                 env_in,
  input logic                 env_out,
  input logic                 label,
  input logic                 virgin,
  input logic                 spd_invalid,
  input logic [SPD_CNT_W-1:0] spd_count,
  input logic [SPD_RNG_W-1:0] spd_range
);
  localparam logic [SPD_RNG_W-1:0] RNG_TOP = {SPD_RNG_W{1'b1}};

  a_r1_label_after_high: assert property (@(posedge clk) disable iff (rst)
    $rose(label) |-> $past(env_out));

  a_r3_virgin_after_low: assert property (@(posedge clk) disable iff (rst)
    $rose(virgin) |-> !$past(env_out));

  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !search_en |=> (!label && !virgin && !env_out && !spd_invalid
                    && spd_count == '0 && spd_range == '0));

  a_r6_env_delay: assert property (@(posedge clk) disable iff (rst)
    search_en |=> (env_out == $past(env_in)));

  // R8 and R9: the reported range moves by at most one step per burst
  a_r8_range_single_step: assert property (@(posedge clk) disable iff (rst)
    (search_en && $past(search_en)) |->
      ({1'b0, spd_range} == {1'b0, $past(spd_range)} ||
       {1'b0, spd_range} == {1'b0, $past(spd_range)} + 3'd1 ||
       {1'b0, spd_range} + 3'd1 == {1'b0, $past(spd_range)}));

  a_r10_valid_in_band: assert property (@(posedge clk) disable iff (rst)
    (search_en && $past(search_en) && !spd_invalid) |->
      (!(spd_count < SPD_CNT_W'(LOW_LIM) && spd_range != RNG_TOP) &&
       !(spd_count > SPD_CNT_W'(HIGH_LIM) && spd_range != '0)));
endmodule

bind aux_env_monitor aux_env_monitor_chk #(
  .LOW_LIM (LOW_LIM),
  .HIGH_LIM(HIGH_LIM)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .search_en  (search_en),
  .env_in     (env_in),
  .env_out    (env_out),
  .label      (label),
  .virgin     (virgin),
  .spd_invalid(spd_invalid),
  .spd_count  (spd_count),
  .spd_range  (spd_range)
);

// File: tb/test_aux_env_monitor.sv
module test_aux_env_monitor;
  localparam int HOLD = 4;
  localparam int BDIV = 32;
  localparam int LOWL = 4;
  localparam int HIGHL = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       search_en = 1'b0;
  logic       env_in = 1'b0;
  logic       blk_tick = 1'b0;
  logic       env_out, label, virgin, spd_invalid;
  logic [4:0] spd_count;
  logic [1:0] spd_range;

  int checks = 0;
  int errors = 0;
  int model_rng = 0;

  always #4 clk = ~clk;

  aux_env_monitor #(
    .HOLD_BLOCKS(HOLD), .BASE_DIV(BDIV), .LOW_LIM(LOWL), .HIGH_LIM(HIGHL)
  ) i_aux_env_monitor (
    .clk(clk), .rst(rst), .search_en(search_en), .env_in(env_in),
    .blk_tick(blk_tick), .env_out(env_out), .label(label), .virgin(virgin),
    .spd_invalid(spd_invalid), .spd_count(spd_count), .spd_range(spd_range)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk) blk_tick = 1'b1;
      @(negedge clk) blk_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic set_env(input logic v);
    @(negedge clk) env_in = v;
    @(negedge clk);
  endtask

  task automatic burst(input int h);
    int c;
    int d;
    int exp_inv;
    int used;
    d = BDIV >> model_rng;
    c = (h - 1) / d;
    if (c > 31) c = 31;
    used = model_rng;
    exp_inv = 0;
    @(negedge clk) env_in = 1'b1;
    repeat (h) @(negedge clk);
    env_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 count", spd_count, c);
    chk("R7 range", spd_range, used);
    if (c < LOWL && model_rng < 3) begin
      model_rng++; exp_inv = 1;
      chk("R8 invalid after up-step", spd_invalid, exp_inv);
    end else if (c > HIGHL && model_rng > 0) begin
      model_rng--; exp_inv = 1;
      chk("R9 invalid after down-step", spd_invalid, exp_inv);
    end else begin
      chk("R10 valid in band", spd_invalid, exp_inv);
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5: reset / idle state
    chk("R5 label", label, 0);
    chk("R5 virgin", virgin, 0);
    chk("R5 env_out", env_out, 0);
    chk("R5 invalid", spd_invalid, 0);
    chk("R5 count", spd_count, 0);

    search_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 invalid on entry", spd_invalid, 1);
    chk("R11 range on entry", spd_range, 0);

    tick(HOLD - 1);
    chk("R4 virgin short low run", virgin, 0);
    tick(1);
    chk("R3 virgin set", virgin, 1);
    chk("R3 label low", label, 0);

    @(negedge clk) env_in = 1'b1;
    @(negedge clk);
    chk("R6 env_out follows", env_out, 1);
    tick(HOLD - 1);
    chk("R4 label short high run", label, 0);
    chk("R4 virgin held", virgin, 1);
    tick(1);
    chk("R1 label set", label, 1);
    chk("R3 virgin cleared", virgin, 0);

    set_env(1'b0);
    tick(HOLD - 1);
    chk("R4 label held", label, 1);
    tick(1);
    chk("R2 label cleared", label, 0);
    chk("R3 virgin after label", virgin, 1);

    // R4: interrupted high run restarts the count
    set_env(1'b1);
    tick(HOLD - 1);
    set_env(1'b0);
    set_env(1'b1);
    tick(HOLD - 1);
    chk("R4 restart label", label, 0);
    tick(1);
    chk("R1 label after restart", label, 1);

    @(negedge clk) search_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 label off", label, 0);
    chk("R5 virgin off", virgin, 0);
    chk("R5 env_out off", env_out, 0);
    chk("R5 invalid off", spd_invalid, 0);
    chk("R5 range off", spd_range, 0);

    env_in = 1'b0;
    @(negedge clk) search_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 invalid re-entry", spd_invalid, 1);
    chk("R11 range re-entry", spd_range, 0);
    model_rng = 0;

    for (int i = 0; i <= 100; i++) burst(1 + i * 11);
    for (int i = 100; i >= 0; i--) burst(1 + i * 11);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule